// File: doc/BRIEF.md
# Video Memory Block Mover

This block moves or fills byte blocks inside a 4 MB video memory. Software programs a sixteen-byte register window with the source and destination start addresses, the size, and two row strides. It then writes a start command to the control byte. The engine drives a byte-wide request/grant memory port until the transfer ends and then raises a sticky completion flag.

A transfer is either linear or rectangular, and either a copy or a constant fill. A linear transfer covers a contiguous run of bytes. A rectangular transfer covers a block of a given width and height. The source and destination each have their own row pitch, so after each row the engine jumps to the next image row instead of to the byte after the block. In a copy, each byte is read from the source and then written to the destination. A fill writes the stored fill byte to every destination byte and reads nothing. Offset 1 serves two purposes: a write to it sets the fill byte, and a read from it returns the engine status.

Top module: `vdma_engine`

## Requirements
- R1: Register window layout (all multi-byte fields little-endian):
  - Offsets 2-4 hold the source address and 5-7 the destination address.
  - Offsets 8-9 hold the linear length low bytes or the block width. Offsets A-B hold the length high byte or the block height.
  - Offsets C-D hold the source pitch and E-F the destination pitch.
  - Reading offsets 2-F returns the stored byte.
  - Reading offset 0 returns {5'b0, fill, rect, enable}, so bit 7 always reads 0.
- R2: A write to offset 1 stores the fill byte. A read of offset 1 returns status: bit 7 is busy, bit 0 is done, and the other bits are 0. Status reads 0x00 after reset.
- R3: A write to offset 0 with bit 7 and bit 0 set while idle starts a transfer. Bit 1 selects rectangular mode and bit 2 selects fill. Busy is visible from the next cycle, and the memory request is raised in that same cycle.
- R4: A linear copy of N bytes (length = bytes A,9,8) reads source+i and then writes that byte to destination+i, for i = 0..N-1 in order.
- R5: A rectangular copy of width W and height H transfers byte (r,c) from src+r*src_pitch+c to dst+r*dst_pitch+c, in row-major order.
- R6: A fill writes the fill byte to every destination address of the transfer. It issues no memory reads and ignores the source address.
- R7: A start with zero length, or in rectangular mode with zero width or zero height, sets done right after the write. Busy never asserts and no memory access is made.
- R8: All addresses wrap modulo 2^22. Address bits 23:22 written by software are ignored.
- R9: Done is set when the last byte write is granted, and busy clears at the same time. Any write to offset 0 clears done.
- R10: While busy, writes to offsets 1-F are ignored. A write to offset 0 changes only the enable bit.
- R11: Clearing the enable bit while busy aborts the transfer. From the next cycle busy and the request are low, and done stays clear.
- R12: A pending request holds its address, direction and write data until it is granted. Read data is taken on the cycle after the read grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 22 | Byte address in video memory |
| mem_wdata | output | 8 | Write data |
| mem_gnt | input | 1 | Grant; the access completes on a clock edge where req and gnt are both high |
| mem_rdata | input | 8 | Read data, valid the cycle after a read grant |

## Verification
Status changes become visible in the cycle after the register write edge that causes them. That holds for busy after a start, done after a zero-size start, and the idle state after an abort, so the bench reads status at the first falling edge after that write. Each memory write is due at the edge where request and grant are both high. The scoreboard monitor sets grant and compares the pending write against the head of the expected queue in the same falling-edge step, which ties every comparison to the exact handshake edge. Read data is returned one edge after the read grant, and stall patterns for the grant test that a request holds steady until it is accepted.

// File: rtl/vdma_pkg.sv
// Shared constants and types for the video memory block mover.
// Assumes a byte-wide memory and a 16-byte register window.
package vdma_pkg;
    localparam int VADDR_W = 22;   // 4 MB video memory
    localparam int REG_AW  = 4;    // sixteen register offsets
    localparam int LEN_W   = 24;   // linear byte count
    localparam int DIM_W   = 16;   // width, height, pitch

    localparam logic [REG_AW-1:0] OFF_CTRL = 4'h0;
    localparam logic [REG_AW-1:0] OFF_STAT = 4'h1;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_READ  = 2'd1,
        W_WAIT  = 2'd2,
        W_WRITE = 2'd3
    } walk_state_t;
endpackage

// File: rtl/vdma_regs.sv
// Register window of the block mover: control, fill byte / status,
// addresses, size and pitches. Assumes one write port and a combinational
// read path. Holds the sticky done flag and decodes start and abort.
module vdma_regs
    import vdma_pkg::*;
#(
    parameter int ADDR_W = VADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy,
    input  logic              finish,
    output logic              done,
    output logic              fill_mode_q,
    output logic [7:0]        fill_byte,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [LEN_W-1:0]  len_lin,
    output logic [DIM_W-1:0]  width,
    output logic [DIM_W-1:0]  height,
    output logic [DIM_W-1:0]  src_pitch,
    output logic [DIM_W-1:0]  dst_pitch,
    output logic              start,
    output logic              start_rect,
    output logic              start_fill,
    output logic              abort
);
    localparam int NREG = 1 << REG_AW;

    logic [7:0] regb [NREG];
    logic       en_q, rect_q;
    logic       ctrl_wr;
    logic [23:0] src24, dst24;

    assign ctrl_wr = reg_wr && (reg_addr == OFF_CTRL);

    // Byte storage for offsets 1..F; locked while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regb[i] <= 8'h00;
        end else if (reg_wr && !busy && reg_addr != OFF_CTRL) begin
            regb[reg_addr] <= reg_wdata;
        end
    end

    // Control bits: enable always writable, mode bits only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            rect_q      <= 1'b0;
            fill_mode_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q <= reg_wdata[0];
            if (!busy) begin
                rect_q      <= reg_wdata[1];
                fill_mode_q <= reg_wdata[2];
            end
        end
    end

    // Sticky done: completion wins over the clearing control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       done <= 1'b0;
        else if (finish)  done <= 1'b1;
        else if (ctrl_wr) done <= 1'b0;
    end

    // Read multiplexer; offset 1 reads status instead of the fill byte.
    always_comb begin
        case (reg_addr)
            OFF_CTRL: reg_rdata = {5'b0, fill_mode_q, rect_q, en_q};
            OFF_STAT: reg_rdata = {busy, 6'b0, done};
            default:  reg_rdata = regb[reg_addr];
        endcase
    end

    assign src24      = {regb[4], regb[3], regb[2]};
    assign dst24      = {regb[7], regb[6], regb[5]};
    assign src_base   = src24[ADDR_W-1:0];
    assign dst_base   = dst24[ADDR_W-1:0];
    assign fill_byte  = regb[1];
    assign len_lin    = {regb[10], regb[9], regb[8]};
    assign width      = {regb[9], regb[8]};
    assign height     = {regb[11], regb[10]};
    assign src_pitch  = {regb[13], regb[12]};
    assign dst_pitch  = {regb[15], regb[14]};
    assign start      = ctrl_wr && reg_wdata[7] && reg_wdata[0] && !busy;
    assign start_rect = reg_wdata[1];
    assign start_fill = reg_wdata[2];
    assign abort      = ctrl_wr && !reg_wdata[0] && busy;
endmodule

// File: rtl/vdma_walker.sv
// Address walker and memory sequencer. Walks rows and columns, then
// issues read/write byte accesses on a request/grant port. Assumes the
// configuration inputs stay stable while busy (the register file locks them).
module vdma_walker
    import vdma_pkg::*;
#(
    parameter int ADDR_W = VADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rect,
    input  logic              start_fill,
    input  logic              abort,
    input  logic [7:0]        fill_byte,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [LEN_W-1:0]  len_lin,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    input  logic [DIM_W-1:0]  src_pitch,
    input  logic [DIM_W-1:0]  dst_pitch,
    output logic              busy,
    output logic              finish,
    output logic              fill_act,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_gnt,
    input  logic [7:0]        mem_rdata
);
    walk_state_t       state;
    logic              rect_act;
    logic [ADDR_W-1:0] src_row, dst_row, src_ptr, dst_ptr;
    logic [LEN_W-1:0]  col_left, row_len;
    logic [DIM_W-1:0]  row_left;
    logic [7:0]        byte_q;
    logic              zero_size, last_col, last_row, wr_done;
    logic [ADDR_W-1:0] src_next_row, dst_next_row;

    assign zero_size = start_rect ? (width == '0 || height == '0) : (len_lin == '0);
    assign row_len   = rect_act ? LEN_W'(width) : len_lin;
    assign last_col  = (col_left == LEN_W'(1));
    assign last_row  = (row_left == DIM_W'(1));
    assign wr_done   = (state == W_WRITE) && mem_gnt;
    assign src_next_row = src_row + ADDR_W'(src_pitch);
    assign dst_next_row = dst_row + ADDR_W'(dst_pitch);

    // Sequencer: launch, read/wait/write per byte, row stepping, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            rect_act <= 1'b0;
            fill_act <= 1'b0;
            src_row  <= '0;
            dst_row  <= '0;
            src_ptr  <= '0;
            dst_ptr  <= '0;
            col_left <= '0;
            row_left <= '0;
            byte_q   <= '0;
        end else if (abort) begin
            state <= W_IDLE;
        end else begin
            case (state)
                W_IDLE: if (start && !zero_size) begin
                    rect_act <= start_rect;
                    fill_act <= start_fill;
                    src_row  <= src_base;
                    dst_row  <= dst_base;
                    src_ptr  <= src_base;
                    dst_ptr  <= dst_base;
                    col_left <= start_rect ? LEN_W'(width) : len_lin;
                    row_left <= start_rect ? height : DIM_W'(1);
                    state    <= start_fill ? W_WRITE : W_READ;
                end
                W_READ: if (mem_gnt) state <= W_WAIT;
                W_WAIT: begin
                    byte_q <= mem_rdata;
                    state  <= W_WRITE;
                end
                W_WRITE: if (wr_done) begin
                    if (last_col && last_row) begin
                        state <= W_IDLE;
                    end else if (last_col) begin
                        row_left <= row_left - DIM_W'(1);
                        col_left <= row_len;
                        src_row  <= src_next_row;
                        dst_row  <= dst_next_row;
                        src_ptr  <= src_next_row;
                        dst_ptr  <= dst_next_row;
                        state    <= fill_act ? W_WRITE : W_READ;
                    end else begin
                        col_left <= col_left - LEN_W'(1);
                        src_ptr  <= src_ptr + ADDR_W'(1);
                        dst_ptr  <= dst_ptr + ADDR_W'(1);
                        state    <= fill_act ? W_WRITE : W_READ;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // Port drive and completion pulse.
    assign busy      = (state != W_IDLE);
    assign mem_req   = (state == W_READ) || (state == W_WRITE);
    assign mem_we    = (state == W_WRITE);
    assign mem_addr  = (state == W_READ) ? src_ptr : dst_ptr;
    assign mem_wdata = fill_act ? fill_byte : byte_q;
    assign finish    = (start && zero_size) || (wr_done && last_col && last_row && !abort);
endmodule

// File: rtl/vdma_engine.sv
// Top of the video memory block mover: register window plus walker.
// Assumes a synchronous byte memory that returns read data one cycle
// after a read grant.
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int ADDR_W = VADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_gnt,
    input  logic [7:0]        mem_rdata
);
    logic              busy, finish, done, fill_cfg, fill_act;
    logic              start, start_rect, start_fill, abort;
    logic [7:0]        fill_byte;
    logic [ADDR_W-1:0] src_base, dst_base;
    logic [LEN_W-1:0]  len_lin;
    logic [DIM_W-1:0]  width, height, src_pitch, dst_pitch;

    vdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .finish(finish), .done(done), .fill_mode_q(fill_cfg),
        .fill_byte(fill_byte), .src_base(src_base), .dst_base(dst_base),
        .len_lin(len_lin), .width(width), .height(height),
        .src_pitch(src_pitch), .dst_pitch(dst_pitch), .start(start),
        .start_rect(start_rect), .start_fill(start_fill), .abort(abort)
    );

    vdma_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rect(start_rect),
        .start_fill(start_fill), .abort(abort), .fill_byte(fill_byte),
        .src_base(src_base), .dst_base(dst_base), .len_lin(len_lin),
        .width(width), .height(height), .src_pitch(src_pitch),
        .dst_pitch(dst_pitch), .busy(busy), .finish(finish),
        .fill_act(fill_act), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata)
    );
endmodule

// File: rtl/vdma_engine_chk.sv
// Property checker for the block mover, bound to the top module.
module vdma_engine_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        reg_addr,
    input logic [7:0]        reg_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_gnt,
    input logic              busy,
    input logic              done,
    input logic              fill_act,
    input logic [7:0]        fill_byte,
    input logic              abort
);
    // R1
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'h0) |-> (reg_rdata[7] == 1'b0));

    // R3
    req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R6
    fill_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fill_act) |-> !(mem_req && !mem_we));

    // R6
    fill_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && fill_act) |-> (mem_wdata == fill_byte));

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R11
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !mem_req && !done));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !abort) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind vdma_engine vdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .busy(busy), .done(done),
    .fill_act(fill_act), .fill_byte(fill_byte), .abort(abort)
);

// File: tb/sim_vdma_engine.sv
module sim_vdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        mem_req, mem_we;
    logic [21:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;

    int tests = 0;
    int fails = 0;
    int wr_count = 0;
    int rd_count = 0;
    int cyc = 0;
    int gnt_mode = 0;
    bit finished = 0;
    string cur_req = "R4";
    logic [29:0] expq[$];

    always #2 clk = ~clk;

    vdma_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b0, a[21:16]} ^ 8'h5A;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Memory model: read data one edge after a read grant.
    always @(posedge clk)
        if (mem_req && !mem_we && mem_gnt) mem_rdata <= pat(mem_addr);

    // Grant driver and scoreboard monitor, both at the falling edge.
    always @(negedge clk) begin
        cyc++;
        case (gnt_mode)
            0: mem_gnt = 1'b1;
            1: mem_gnt = (cyc % 3) != 0;
            default: mem_gnt = 1'b0;
        endcase
        if (mem_req && !mem_we && mem_gnt) rd_count++;
        if (mem_req && mem_we && mem_gnt) begin
            wr_count++;
            if (expq.size() == 0) begin
                check({cur_req, " unexpected write"}, 1, 0);
            end else begin
                logic [29:0] e;
                e = expq.pop_front();
                check({cur_req, " write addr/data"}, {mem_addr, mem_wdata}, e);
            end
        end
        if (cyc > 150000 && !finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic setup(input logic [23:0] s, input logic [23:0] d,
                         input logic [15:0] lo, input logic [15:0] hi,
                         input logic [15:0] sp, input logic [15:0] dp);
        wr(4'h2, s[7:0]);  wr(4'h3, s[15:8]); wr(4'h4, s[23:16]);
        wr(4'h5, d[7:0]);  wr(4'h6, d[15:8]); wr(4'h7, d[23:16]);
        wr(4'h8, lo[7:0]); wr(4'h9, lo[15:8]);
        wr(4'hA, hi[7:0]); wr(4'hB, hi[15:8]);
        wr(4'hC, sp[7:0]); wr(4'hD, sp[15:8]);
        wr(4'hE, dp[7:0]); wr(4'hF, dp[15:8]);
    endtask

    // Driver side of the scoreboard: expected writes in row-major order.
    task automatic expect_block(input logic [21:0] s, input logic [21:0] d,
                                input int w, input int h, input int sp,
                                input int dp, input bit fill, input logic [7:0] fb);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++) begin
                logic [21:0] sa, da;
                sa = s + 22'(r * sp) + 22'(c);
                da = d + 22'(r * dp) + 22'(c);
                expq.push_back({da, fill ? fb : pat(sa)});
            end
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] st;
        int n = 0;
        do begin
            @(negedge clk);
            rd(4'h1, st);
            n++;
        end while (st[7] && n < 5000);
        check({req, " status after end"}, st, 8'h01);
        check({req, " queue drained"}, expq.size(), 0);
    endtask

    initial begin
        logic [7:0] v;
        int wc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset status
        rd(4'h1, v); check("R2 reset status", v, 8'h00);
        rd(4'h5, v); check("R1 reset reg", v, 8'h00);

        // R1 readback and control bit 7
        setup(24'h000100, 24'h004000, 16'd5, 16'h0000, 16'h0000, 16'h0000);
        rd(4'h3, v); check("R1 src mid", v, 8'h01);
        rd(4'h6, v); check("R1 dst mid", v, 8'h40);
        rd(4'h8, v); check("R1 size low", v, 8'h05);

        // R4 linear copy, full grant
        cur_req = "R4";
        expect_block(22'h000100, 22'h004000, 5, 1, 0, 0, 0, 8'h00);
        wr(4'h0, 8'h81);
        rd(4'h1, v); check("R3 busy after start", v, 8'h80);
        rd(4'h0, v); check("R1 ctrl readback", v, 8'h01);
        wait_idle("R4");

        // R9 control write clears done
        wr(4'h0, 8'h01);
        rd(4'h1, v); check("R9 done cleared", v, 8'h00);

        // R5 rectangular copy with stalls, plus R10 writes while busy
        gnt_mode = 1;
        cur_req = "R5";
        setup(24'h001000, 24'h008000, 16'd3, 16'd2, 16'h0040, 16'h0020);
        expect_block(22'h001000, 22'h008000, 3, 2, 'h40, 'h20, 0, 8'h00);
        wr(4'h0, 8'h83);
        wr(4'h5, 8'h77);
        wr(4'h0, 8'h07);
        wait_idle("R5");
        rd(4'h5, v); check("R10 dst byte kept", v, 8'h00);
        rd(4'h0, v); check("R10 ctrl mode kept", v, 8'h03);

        // R6 rectangular fill, no reads
        gnt_mode = 0;
        cur_req = "R6";
        wr(4'h1, 8'hC3);
        setup(24'h005555, 24'h002000, 16'd4, 16'd3, 16'h0011, 16'h0100);
        expect_block(22'h0, 22'h002000, 4, 3, 0, 'h100, 1, 8'hC3);
        wc = rd_count;
        wr(4'h0, 8'h87);
        wait_idle("R6");
        check("R6 no reads", rd_count - wc, 0);

        // R6 linear fill with stalls
        gnt_mode = 1;
        wr(4'h1, 8'h3C);
        setup(24'h000000, 24'h00A000, 16'd7, 16'h0000, 16'h0, 16'h0);
        expect_block(22'h0, 22'h00A000, 7, 1, 0, 0, 1, 8'h3C);
        wr(4'h0, 8'h85);
        wait_idle("R6");

        // R8 wrap and ignored upper address bits
        gnt_mode = 0;
        cur_req = "R8";
        setup(24'hC00010, 24'hFFFFFE, 16'd4, 16'h0000, 16'h0, 16'h0);
        expect_block(22'h000010, 22'h3FFFFE, 4, 1, 0, 0, 0, 8'h00);
        wr(4'h0, 8'h81);
        wait_idle("R8");

        // R7 zero length, zero height
        wc = wr_count;
        setup(24'h0, 24'h0, 16'd0, 16'h0000, 16'h0, 16'h0);
        wr(4'h0, 8'h81);
        rd(4'h1, v); check("R7 zero length done", v, 8'h01);
        setup(24'h0, 24'h0, 16'd4, 16'd0, 16'h0, 16'h0);
        wr(4'h0, 8'h83);
        rd(4'h1, v); check("R7 zero height done", v, 8'h01);
        repeat (4) @(negedge clk);
        check("R7 no writes", wr_count - wc, 0);

        // R12 held request, then R11 abort
        gnt_mode = 2;
        setup(24'h000300, 24'h000600, 16'd3, 16'h0000, 16'h0, 16'h0);
        wr(4'h0, 8'h81);
        repeat (3) @(negedge clk);
        check("R12 req held", mem_req, 1);
        check("R12 addr held", mem_addr, 22'h000300);
        check("R12 read dir", mem_we, 0);
        wr(4'h0, 8'h00);
        rd(4'h1, v); check("R11 abort status", v, 8'h00);
        check("R11 req dropped", mem_req, 0);
        gnt_mode = 0;

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule